// File: doc/BRIEF.md
# Privileged Status and Trap Controller

This block keeps a processor core's privileged machine state. It holds a 32-bit status word, the trap cause, the PC saved at a trap, the trap vector, the last faulting address, two scratch words and a pair of host mailbox words. Each cycle it reports whether an enabled interrupt is waiting and which cause code the core should raise for it. When the core signals a trap, the block updates the status word, records the trap details and drives a PC redirect to the vector register in the same cycle.

Software reaches the registers through a simple indexed port. Reads are combinational. Writes take effect at the next clock edge. Some writes have side effects: writing the status word requests a TLB flush, and writes to the IPI-clear and from-host registers change interrupt-pending bits. Interrupt sources raise and drop their pending bits through a separate set/clear bus. Every pin is a plain control or data pin with no handshake. The core must present each access or trap for exactly one cycle.

Top module: `priv_trap_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), status becomes 0x44: supervisor bit 2 is set, and 64-bit bit 6 is set when EN64=1. Every other register becomes 0. In the first cycle after release, redirect_valid is 1 and redirect_pc is RESET_PC (0x2000).
- R2: irq_take is 1 only when status bit 0 (enable) is 1 and pending bits 31:24 AND mask bits 23:16 are nonzero. The lowest set index wins.
- R3: irq_cause is the winning index with bit 63 set when status bit 6 is 1, and with bit 31 set otherwise.
- R4: A trap (trap_req) copies old bit 2 into bit 3, copies old bit 0 into bit 1, sets bit 2 and clears bit 0.
- R5: A trap loads cause (index 4) from trap_cause and EPC (index 1) from trap_pc. It loads the bad address (index 2) only when trap_badaddr_vld is 1. In the same cycle it drives redirect_valid=1 with redirect_pc equal to the vector register (index 3).
- R6: A write to status (index 0) keeps bits 31:24 unchanged. It forces to 0 the reserved bits 15:9, the FP bit 4 when EN_FPU=0, the vector bit 8 when EN_VEC=0, and bits 6 and 5 when EN64=0. It pulses tlb_flush in the write cycle.
- R7: A write to index 11 sets pending bit 5 (inter-processor) to wdata[0].
- R8: Index 12 (to-host) accepts a write only while it holds 0.
- R9: A write to index 13 (from-host) stores the value and sets pending bit 6 exactly when the value is nonzero.
- R10: Reading index 5 returns 0 and index 7 returns HART_ID. Index 8 returns 1. Reading index 6 with csr_rd_en returns 0 and pulses tlb_flush. Every index not listed reads as all ones.
- R11: When trap_req and csr_wr_en coincide, the trap applies and the write is dropped, so it causes no flush.
- R12: For each bit, irq_set and irq_clr update the pending bits at the next edge, and set wins over clear. A same-cycle write to index 11 or 13 overrides the bus for its bit.
- R13: Indexes 1, 3, 9 and 10 are writable and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 5 | Register index for read and write |
| csr_wr_en | input | 1 | Write strobe |
| csr_rd_en | input | 1 | Read strobe, used only for read side effects |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data |
| irq_set | input | NIRQ | Per-source pending set |
| irq_clr | input | NIRQ | Per-source pending clear |
| irq_take | output | 1 | An enabled interrupt is pending |
| irq_cause | output | XLEN | Cause code for the winning interrupt |
| trap_req | input | 1 | Trap entry this cycle |
| trap_cause | input | XLEN | Cause to record |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_badaddr_vld | input | 1 | trap_badaddr is meaningful |
| trap_badaddr | input | XLEN | Faulting address |
| redirect_valid | output | 1 | Next PC must be redirect_pc |
| redirect_pc | output | XLEN | Redirect target |
| tlb_flush | output | 1 | TLB flush request pulse |

## Verification
A trap and a software register write can land in the same cycle. The bench asserts trap_req while writing EPC and, separately, while writing the status word. It passes only if EPC holds the trap PC, status shows the trap-entry transform rather than the written value, and tlb_flush stays low. A pending-bit collision is also driven: the set/clear bus and an IPI-clear write target one bit together. The bench then reads back status to confirm that the register write wins.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  localparam int SR_W    = 32;
  localparam int B_EI    = 0;
  localparam int B_PEI   = 1;
  localparam int B_S     = 2;
  localparam int B_PS    = 3;
  localparam int B_EF    = 4;
  localparam int B_U64   = 5;
  localparam int B_S64   = 6;
  localparam int B_VM    = 7;
  localparam int B_EV    = 8;
  localparam int IM_LSB  = 16;
  localparam int IP_LSB  = 24;
  localparam int FIELD_W = 8;
  localparam int IRQ_IPI  = 5;
  localparam int IRQ_HOST = 6;

  typedef enum logic [4:0] {
    RA_STATUS   = 5'd0,
    RA_EPC      = 5'd1,
    RA_BADADDR  = 5'd2,
    RA_EVEC     = 5'd3,
    RA_CAUSE    = 5'd4,
    RA_ASID     = 5'd5,
    RA_TLBFL    = 5'd6,
    RA_HART     = 5'd7,
    RA_IMPL     = 5'd8,
    RA_SCR0     = 5'd9,
    RA_SCR1     = 5'd10,
    RA_IPICLR   = 5'd11,
    RA_TOHOST   = 5'd12,
    RA_FROMHOST = 5'd13
  } reg_addr_e;

  // Bits software may change in the status word (pending field excluded).
  function automatic logic [SR_W-1:0] wr_mask_f(bit en64, bit en_fpu, bit en_vec, int nirq);
    logic [SR_W-1:0] m;
    m = '0;
    m[B_EI]  = 1'b1;
    m[B_PEI] = 1'b1;
    m[B_S]   = 1'b1;
    m[B_PS]  = 1'b1;
    m[B_VM]  = 1'b1;
    m[B_EF]  = en_fpu;
    m[B_U64] = en64;
    m[B_S64] = en64;
    m[B_EV]  = en_vec;
    for (int i = 0; i < nirq; i++) m[IM_LSB+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/priv_irq_pick.sv
module priv_irq_pick #(
  parameter int NIRQ  = 8,
  parameter int IDX_W = 3
) (
  input  logic [NIRQ-1:0]  pend,
  input  logic [NIRQ-1:0]  mask,
  input  logic             glob_en,
  output logic             take,
  output logic [IDX_W-1:0] idx
);
  logic [NIRQ-1:0] live;
  logic            seen;

  assign live = pend & mask;
  assign take = glob_en & (|live);

  // Lowest-numbered live source wins.
  always_comb begin
    idx  = '0;
    seen = 1'b0;
    for (int i = 0; i < NIRQ; i++) begin
      if (live[i] && !seen) begin
        idx  = IDX_W'(i);
        seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/priv_sr_update.sv
module priv_sr_update
  import priv_trap_pkg::*;
#(
  parameter bit EN64   = 1'b1,
  parameter bit EN_FPU = 1'b0,
  parameter bit EN_VEC = 1'b0,
  parameter int NIRQ   = 8
) (
  input  logic [SR_W-1:0] sr_q,
  input  logic [NIRQ-1:0] ip_nx,
  input  logic            trap,
  input  logic            wr_sr,
  input  logic [SR_W-1:0] wdata,
  output logic [SR_W-1:0] sr_d
);
  localparam logic [SR_W-1:0] WMASK = wr_mask_f(EN64, EN_FPU, EN_VEC, NIRQ);

  logic [SR_W-1:0] base;

  always_comb begin
    base = sr_q;
    if (trap) begin
      base[B_PS]  = sr_q[B_S];
      base[B_PEI] = sr_q[B_EI];
      base[B_S]   = 1'b1;
      base[B_EI]  = 1'b0;
    end else if (wr_sr) begin
      base = wdata & WMASK;
    end
    sr_d = base;
    sr_d[IP_LSB +: NIRQ] = ip_nx;
  end
endmodule

// File: rtl/priv_csr_rdmux.sv
module priv_csr_rdmux
  import priv_trap_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int HART_ID = 0
) (
  input  logic [4:0]      addr,
  input  logic [SR_W-1:0] sr,
  input  logic [XLEN-1:0] epc,
  input  logic [XLEN-1:0] badaddr,
  input  logic [XLEN-1:0] evec,
  input  logic [XLEN-1:0] cause,
  input  logic [XLEN-1:0] scr0,
  input  logic [XLEN-1:0] scr1,
  input  logic [XLEN-1:0] tohost,
  input  logic [XLEN-1:0] fromhost,
  output logic [XLEN-1:0] rdata
);
  always_comb begin
    case (addr)
      RA_STATUS:   rdata = XLEN'(sr);
      RA_EPC:      rdata = epc;
      RA_BADADDR:  rdata = badaddr;
      RA_EVEC:     rdata = evec;
      RA_CAUSE:    rdata = cause;
      RA_ASID:     rdata = '0;
      RA_TLBFL:    rdata = '0;
      RA_HART:     rdata = XLEN'(HART_ID);
      RA_IMPL:     rdata = XLEN'(1);
      RA_SCR0:     rdata = scr0;
      RA_SCR1:     rdata = scr1;
      RA_TOHOST:   rdata = tohost;
      RA_FROMHOST: rdata = fromhost;
      default:     rdata = '1;
    endcase
  end
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter int              NIRQ     = 8,
  parameter int              HART_ID  = 0,
  parameter bit              EN64     = 1'b1,
  parameter bit              EN_FPU   = 1'b0,
  parameter bit              EN_VEC   = 1'b0,
  parameter logic [63:0]     RESET_PC = 64'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      csr_addr,
  input  logic            csr_wr_en,
  input  logic            csr_rd_en,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [NIRQ-1:0] irq_set,
  input  logic [NIRQ-1:0] irq_clr,
  output logic            irq_take,
  output logic [XLEN-1:0] irq_cause,
  input  logic            trap_req,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            trap_badaddr_vld,
  input  logic [XLEN-1:0] trap_badaddr,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            tlb_flush
);
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam logic [SR_W-1:0] SR_RST = (SR_W'(1) << B_S) | (SR_W'(EN64) << B_S64);

  logic [SR_W-1:0] sr_q, sr_d;
  logic [XLEN-1:0] epc_q, badaddr_q, evec_q, cause_q, scr0_q, scr1_q, tohost_q, fromhost_q;
  logic            boot_q;
  logic [NIRQ-1:0] ip_cur, ip_nx;
  logic [IDX_W-1:0] irq_idx;
  logic            wr_ok;

  // A trap in the same cycle cancels the software write.
  assign wr_ok  = csr_wr_en & ~trap_req;
  assign ip_cur = sr_q[IP_LSB +: NIRQ];

  always_comb begin
    ip_nx = (ip_cur & ~irq_clr) | irq_set;
    if (wr_ok && csr_addr == RA_IPICLR)   ip_nx[IRQ_IPI]  = csr_wdata[0];
    if (wr_ok && csr_addr == RA_FROMHOST) ip_nx[IRQ_HOST] = |csr_wdata;
  end

  priv_sr_update #(
    .EN64(EN64), .EN_FPU(EN_FPU), .EN_VEC(EN_VEC), .NIRQ(NIRQ)
  ) u_sr_upd (
    .sr_q  (sr_q),
    .ip_nx (ip_nx),
    .trap  (trap_req),
    .wr_sr (wr_ok && csr_addr == RA_STATUS),
    .wdata (csr_wdata[SR_W-1:0]),
    .sr_d  (sr_d)
  );

  priv_irq_pick #(.NIRQ(NIRQ), .IDX_W(IDX_W)) u_pick (
    .pend    (ip_cur),
    .mask    (sr_q[IM_LSB +: NIRQ]),
    .glob_en (sr_q[B_EI]),
    .take    (irq_take),
    .idx     (irq_idx)
  );

  always_comb begin
    irq_cause = '0;
    irq_cause[IDX_W-1:0] = irq_idx;
    if (sr_q[B_S64]) irq_cause[XLEN-1] = 1'b1;
    else             irq_cause[31]     = 1'b1;
  end

  priv_csr_rdmux #(.XLEN(XLEN), .HART_ID(HART_ID)) u_rdmux (
    .addr     (csr_addr),
    .sr       (sr_q),
    .epc      (epc_q),
    .badaddr  (badaddr_q),
    .evec     (evec_q),
    .cause    (cause_q),
    .scr0     (scr0_q),
    .scr1     (scr1_q),
    .tohost   (tohost_q),
    .fromhost (fromhost_q),
    .rdata    (csr_rdata)
  );

  assign redirect_valid = trap_req | boot_q;
  assign redirect_pc    = trap_req ? evec_q : XLEN'(RESET_PC);
  assign tlb_flush      = (wr_ok && csr_addr == RA_STATUS) ||
                          (csr_rd_en && csr_addr == RA_TLBFL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= SR_RST;
      epc_q      <= '0;
      badaddr_q  <= '0;
      evec_q     <= '0;
      cause_q    <= '0;
      scr0_q     <= '0;
      scr1_q     <= '0;
      tohost_q   <= '0;
      fromhost_q <= '0;
      boot_q     <= 1'b1;
    end else begin
      sr_q   <= sr_d;
      boot_q <= 1'b0;
      if (trap_req) begin
        cause_q <= trap_cause;
        epc_q   <= trap_pc;
        if (trap_badaddr_vld) badaddr_q <= trap_badaddr;
      end else if (wr_ok) begin
        case (csr_addr)
          RA_EPC:      epc_q      <= csr_wdata;
          RA_EVEC:     evec_q     <= csr_wdata;
          RA_SCR0:     scr0_q     <= csr_wdata;
          RA_SCR1:     scr1_q     <= csr_wdata;
          RA_TOHOST:   if (tohost_q == '0) tohost_q <= csr_wdata;
          RA_FROMHOST: fromhost_q <= csr_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/priv_trap_ctrl_chk.sv
module priv_trap_ctrl_chk
  import priv_trap_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic            csr_wr_en,
  input logic            csr_rd_en,
  input logic [4:0]      csr_addr,
  input logic [NIRQ-1:0] irq_set,
  input logic [NIRQ-1:0] irq_clr,
  input logic            irq_take,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            tlb_flush,
  input logic [SR_W-1:0] sr_q,
  input logic [XLEN-1:0] evec_q,
  input logic [XLEN-1:0] tohost_q
);
  // R2: an interrupt is offered only with the global enable set
  a_r2_take_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> sr_q[B_EI]);

  // R4: trap entry status transform
  a_r4_trap_status: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (sr_q[B_S] && !sr_q[B_EI] &&
                  sr_q[B_PS] == $past(sr_q[B_S]) && sr_q[B_PEI] == $past(sr_q[B_EI])));

  // R5: redirect to the vector in the trap cycle
  a_r5_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (redirect_valid && redirect_pc == evec_q));

  // R6: a status write alone leaves the pending field untouched
  a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_en && !trap_req && csr_addr == RA_STATUS && irq_set == '0 && irq_clr == '0)
      |=> sr_q[IP_LSB +: NIRQ] == $past(sr_q[IP_LSB +: NIRQ]));

  // R8: once nonzero, the to-host word holds
  a_r8_tohost_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (tohost_q != '0) |=> $stable(tohost_q));

  // R11: a trap suppresses the write-driven flush
  a_r11_trap_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !(csr_rd_en && csr_addr == RA_TLBFL)) |-> !tlb_flush);
endmodule

bind priv_trap_ctrl priv_trap_ctrl_chk #(.XLEN(XLEN), .NIRQ(NIRQ)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .trap_req       (trap_req),
  .csr_wr_en      (csr_wr_en),
  .csr_rd_en      (csr_rd_en),
  .csr_addr       (csr_addr),
  .irq_set        (irq_set),
  .irq_clr        (irq_clr),
  .irq_take       (irq_take),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .tlb_flush      (tlb_flush),
  .sr_q           (sr_q),
  .evec_q         (evec_q),
  .tohost_q       (tohost_q)
);

// File: tb/priv_trap_ctrl_test.sv
`timescale 1ns/1ps
module priv_trap_ctrl_test;
  localparam int XLEN = 64;
  localparam int NIRQ = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      csr_addr = '0;
  logic            csr_wr_en = 1'b0;
  logic            csr_rd_en = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic [NIRQ-1:0] irq_set = '0;
  logic [NIRQ-1:0] irq_clr = '0;
  logic            irq_take;
  logic [XLEN-1:0] irq_cause;
  logic            trap_req = 1'b0;
  logic [XLEN-1:0] trap_cause = '0;
  logic [XLEN-1:0] trap_pc = '0;
  logic            trap_badaddr_vld = 1'b0;
  logic [XLEN-1:0] trap_badaddr = '0;
  logic            redirect_valid;
  logic [XLEN-1:0] redirect_pc;
  logic            tlb_flush;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  priv_trap_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ), .HART_ID(3)) uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr_en(csr_wr_en),
    .csr_rd_en(csr_rd_en), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_set(irq_set), .irq_clr(irq_clr), .irq_take(irq_take), .irq_cause(irq_cause),
    .trap_req(trap_req), .trap_cause(trap_cause), .trap_pc(trap_pc),
    .trap_badaddr_vld(trap_badaddr_vld), .trap_badaddr(trap_badaddr),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .tlb_flush(tlb_flush)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  wa;
    logic [63:0] wd;
    logic [4:0]  ra;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b1, 5'd1,  64'h1234_5678_9abc_def0, 5'd1,  64'h1234_5678_9abc_def0, 4'd13}, // R13 EPC
    '{1'b1, 5'd3,  64'h8000,                5'd3,  64'h8000,                4'd13}, // R13 vector
    '{1'b1, 5'd9,  64'hdead,                5'd9,  64'hdead,                4'd13}, // R13 scratch
    '{1'b1, 5'd10, 64'hffff_ffff_ffff_ffff, 5'd10, 64'hffff_ffff_ffff_ffff, 4'd13}, // R13 scratch
    '{1'b1, 5'd0,  64'hffff_ffff_ffff_ffff, 5'd0,  64'h00ff_00ef,           4'd6},  // R6 masking
    '{1'b1, 5'd0,  64'h44,                  5'd0,  64'h44,                  4'd6},  // R6 restore
    '{1'b0, 5'd0,  64'h0,                   5'd5,  64'h0,                   4'd10}, // R10 ASID
    '{1'b0, 5'd0,  64'h0,                   5'd7,  64'h3,                   4'd10}, // R10 hart
    '{1'b0, 5'd0,  64'h0,                   5'd8,  64'h1,                   4'd10}, // R10 impl
    '{1'b0, 5'd0,  64'h0,                   5'd20, 64'hffff_ffff_ffff_ffff, 4'd10}, // R10 unknown
    '{1'b1, 5'd12, 64'h55,                  5'd12, 64'h55,                  4'd8},  // R8 first
    '{1'b1, 5'd12, 64'h77,                  5'd12, 64'h55,                  4'd8},  // R8 locked
    '{1'b1, 5'd13, 64'h9,                   5'd0,  64'h4000_0044,           4'd9},  // R9 host set
    '{1'b1, 5'd13, 64'h0,                   5'd0,  64'h44,                  4'd9},  // R9 host clear
    '{1'b1, 5'd11, 64'h1,                   5'd0,  64'h2000_0044,           4'd7},  // R7 ipi set
    '{1'b1, 5'd11, 64'h2,                   5'd0,  64'h44,                  4'd7}   // R7 ipi clear
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called 1 ns after a rising edge; commits at the next edge.
  task automatic csr_write(input logic [4:0] a, input logic [63:0] d);
    csr_addr = a; csr_wdata = d; csr_wr_en = 1'b1;
    @(posedge clk); #1;
    csr_wr_en = 1'b0;
  endtask

  task automatic csr_read(input logic [4:0] a, output logic [63:0] d);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic pulse_bus(input logic [NIRQ-1:0] s, input logic [NIRQ-1:0] c);
    irq_set = s; irq_clr = c;
    @(posedge clk); #1;
    irq_set = '0; irq_clr = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 boot redirect valid", 64'(redirect_valid), 64'h1);
    chk("R1 boot redirect pc", redirect_pc, 64'h2000);
    csr_read(5'd0, rd); chk("R1 reset status", rd, 64'h44);
    csr_read(5'd4, rd); chk("R1 reset cause", rd, 64'h0);
    csr_read(5'd1, rd); chk("R1 reset epc", rd, 64'h0);
    chk("R1 reset no irq", 64'(irq_take), 64'h0);
    @(posedge clk); #1;
    chk("R1 boot redirect drops", 64'(redirect_valid), 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].wr) csr_write(VT[i].wa, VT[i].wd);
      csr_read(VT[i].ra, rd);
      chk($sformatf("R%0d vector %0d", VT[i].req, i), rd, VT[i].exp);
    end

    // R2 / R3: interrupt selection and cause encoding
    csr_write(5'd0, 64'h00ff_0045);
    pulse_bus(8'h28, 8'h00);
    chk("R2 take with enable", 64'(irq_take), 64'h1);
    chk("R3 cause 64-bit flag", irq_cause, 64'h8000_0000_0000_0003);
    csr_write(5'd0, 64'h00f0_0045);
    chk("R2 mask selects idx5", irq_cause, 64'h8000_0000_0000_0005);
    csr_write(5'd0, 64'h00ff_0005);
    chk("R3 cause 32-bit flag", irq_cause, 64'h0000_0000_8000_0003);
    csr_write(5'd0, 64'h00ff_0044);
    chk("R2 no take when disabled", 64'(irq_take), 64'h0);

    // R12: bus set/clear, set wins over clear
    pulse_bus(8'h01, 8'h09);
    csr_read(5'd0, rd); chk("R12 set beats clear", rd, 64'h21ff_0044);
    // R12: register side effect overrides the bus
    irq_clr = 8'h21;
    csr_write(5'd11, 64'h1);
    irq_clr = '0;
    csr_read(5'd0, rd); chk("R12 ipi write overrides clear", rd, 64'h20ff_0044);
    pulse_bus(8'h00, 8'hff);

    // R4 / R5: trap from supervisor with enable on
    csr_write(5'd0, 64'h00ff_0045);
    trap_req = 1'b1; trap_cause = 64'h2; trap_pc = 64'h3000;
    trap_badaddr_vld = 1'b1; trap_badaddr = 64'hbad;
    #1;
    chk("R5 redirect valid", 64'(redirect_valid), 64'h1);
    chk("R5 redirect pc", redirect_pc, 64'h8000);
    @(posedge clk); #1;
    trap_req = 1'b0; trap_badaddr_vld = 1'b0;
    csr_read(5'd0, rd); chk("R4 status after trap", rd, 64'h00ff_004e);
    csr_read(5'd4, rd); chk("R5 cause", rd, 64'h2);
    csr_read(5'd1, rd); chk("R5 epc", rd, 64'h3000);
    csr_read(5'd2, rd); chk("R5 badaddr", rd, 64'hbad);

    // R4 / R5: trap from user mode, no bad address
    csr_write(5'd0, 64'h40);
    trap_req = 1'b1; trap_cause = 64'h7; trap_pc = 64'h3100;
    @(posedge clk); #1;
    trap_req = 1'b0;
    csr_read(5'd0, rd); chk("R4 user trap status", rd, 64'h44);
    csr_read(5'd2, rd); chk("R5 badaddr kept", rd, 64'hbad);

    // R11: trap and write together
    trap_req = 1'b1; trap_cause = 64'h9; trap_pc = 64'h4000;
    csr_write(5'd1, 64'h9999);
    trap_req = 1'b0;
    csr_read(5'd1, rd); chk("R11 epc from trap", rd, 64'h4000);
    trap_req = 1'b1; trap_pc = 64'h4100;
    csr_addr = 5'd0; csr_wdata = 64'hffff; csr_wr_en = 1'b1;
    #1 chk("R11 no flush under trap", 64'(tlb_flush), 64'h0);
    @(posedge clk); #1;
    csr_wr_en = 1'b0; trap_req = 1'b0;
    csr_read(5'd0, rd); chk("R11 status write dropped", rd, 64'h4c);

    // R6 flush on status write
    csr_addr = 5'd0; csr_wdata = 64'h44; csr_wr_en = 1'b1;
    #1 chk("R6 flush on status write", 64'(tlb_flush), 64'h1);
    @(posedge clk); #1;
    csr_wr_en = 1'b0;

    // R10 flush register read
    csr_rd_en = 1'b1; csr_addr = 5'd6;
    #1;
    chk("R10 flush reg reads zero", csr_rdata, 64'h0);
    chk("R10 flush reg read pulses", 64'(tlb_flush), 64'h1);
    csr_rd_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule